// File: doc/BRIEF.md
# Pipelined Non-Restoring Integer Divider

This block divides an unsigned dividend by an unsigned divisor of the same width. It returns the quotient and the remainder. The work is split over a chain of stages. Each stage resolves a fixed share of the quotient bits. A stage keeps one operation for a fixed number of clocks, resolving a fixed number of quotient bits per clock, then hands it to the next stage. Several divisions can therefore be in progress at once, one per stage.

Each quotient bit comes from one non-restoring step. The partial remainder and the next dividend bit are shifted left. The divisor is subtracted when the partial remainder is non-negative and added when it is negative. No restore happens between steps. After the final step, a negative partial remainder is corrected once by adding the divisor back.

Two parameters set the folding: quotient bits per clock and clocks per stage. Their product is the number of bits a stage covers. The stage count is the width divided by that product, rounded up, so the last stage may do fewer steps than the others. Setting clocks per stage equal to the width, with one bit per clock, gives a single fully blocking stage. A zero divisor yields a quotient of zero and returns the dividend as remainder.

Both sides use a valid/ready handshake. A transfer takes place on a rising clock edge where valid and ready are both high.

Top module: `nrdiv_pipe`

## Requirements
- R1: For a non-zero divisor, `out_quotient` equals the unsigned integer quotient (dividend / divisor) and `out_remainder` equals dividend mod divisor, at the full operand width.
- R2: For a divisor of zero, `out_quotient` is 0 and `out_remainder` equals the dividend.
- R3: The stage count is ceil(WIDTH / (ITERS_PER_CYCLE * CYCLES_PER_STAGE)). Results stay correct when WIDTH is not a multiple of that product, as in WIDTH=13, 2 bits per clock, 3 clocks per stage: three stages, with the last one doing a single step.
- R4: Each stage holds at most one operation. `in_ready` is low in the cycle after an accepted request whenever CYCLES_PER_STAGE > 1. With `out_ready` held low, exactly as many requests are accepted as there are stages.
- R5: Results leave in the order the requests were accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_quotient` and `out_remainder` stay unchanged. No result is lost.
- R7: With the pipeline empty and `out_ready` high, a request accepted at edge e gives `out_valid` high after edge e + STAGES*CYCLES_PER_STAGE - 1.
- R8: With a request always pending and `out_ready` high, results leave exactly one every CYCLES_PER_STAGE cycles.
- R9: While reset is high and right after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | First stage can take a request |
| in_dividend | input | WIDTH | Unsigned dividend |
| in_divisor | input | WIDTH | Unsigned divisor |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | WIDTH | Quotient (0 for a zero divisor) |
| out_remainder | output | WIDTH | Remainder (dividend for a zero divisor) |

## Verification
A stage counter off by one appears at the ports within one operation, as a latency other than STAGES*CYCLES_PER_STAGE-1. In a back-to-back stream it shows as a result spacing other than CYCLES_PER_STAGE. A wrong add/subtract choice or a misplaced step guard corrupts the remainder and quotient of the very next result. The odd-width configuration exposes a guard error in the short last stage. A handshake fault in a middle stage appears as a changed output during a stall, as a dropped or reordered result, or as a wrong count of requests accepted while the output is blocked.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    // Integer division rounded up, used for stage count derivation.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Global step index of step `it` in clock `cyc` of stage `stg`.
    function automatic int step_index(input int stg, input int bits_per_stage,
                                      input int cyc, input int per_cycle, input int it);
        return stg * bits_per_stage + cyc * per_cycle + it;
    endfunction

endpackage

// File: rtl/nrdiv_stage.sv
module nrdiv_stage
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = 48,
    parameter int IPC   = 1,
    parameter int CPS   = 16,
    parameter int STAGE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH+1:0] up_rem,
    input  logic [WIDTH-1:0] up_quo,
    input  logic [WIDTH-1:0] up_div,
    input  logic             up_zero,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH+1:0] dn_rem,
    output logic [WIDTH-1:0] dn_quo,
    output logic [WIDTH-1:0] dn_div,
    output logic             dn_zero
);
    localparam int BPS = IPC * CPS;
    localparam int CW  = $clog2(CPS + 1);

    logic             busy;
    logic [CW-1:0]    cnt;
    logic [WIDTH+1:0] rem_q, nx_rem;
    logic [WIDTH-1:0] quo_q, nx_quo, div_q;
    logic             zero_q;
    logic             done, take;

    assign done     = busy && (cnt == CW'(CPS));
    assign up_ready = !busy || (done && dn_ready);
    assign take     = up_valid && up_ready;

    // Steps for this clock: on load the first clock's steps are applied
    // to the incoming record, otherwise to the held one.
    always_comb begin
        logic [WIDTH+1:0] sh;
        logic [WIDTH-1:0] dv;
        int               cyc;
        nx_rem = take ? up_rem : rem_q;
        nx_quo = take ? up_quo : quo_q;
        dv     = take ? up_div : div_q;
        cyc    = take ? 0 : int'(cnt);
        sh     = '0;
        for (int i = 0; i < IPC; i++) begin
            if (step_index(STAGE, BPS, cyc, IPC, i) < WIDTH) begin
                sh = {nx_rem[WIDTH:0], nx_quo[WIDTH-1]};
                if (nx_rem[WIDTH+1])
                    sh = sh + {2'b00, dv};
                else
                    sh = sh - {2'b00, dv};
                nx_quo = {nx_quo[WIDTH-2:0], ~sh[WIDTH+1]};
                nx_rem = sh;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
        end else if (done && dn_ready) begin
            busy <= 1'b0;
        end else if (busy && !done) begin
            cnt <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (take || (busy && !done)) begin
            rem_q <= nx_rem;
            quo_q <= nx_quo;
        end
        if (take) begin
            div_q  <= up_div;
            zero_q <= up_zero;
        end
    end

    assign dn_valid = done;
    assign dn_rem   = rem_q;
    assign dn_quo   = quo_q;
    assign dn_div   = div_q;
    assign dn_zero  = zero_q;

    // R6: a finished record waiting on a stalled neighbour is held intact
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_rem) && $stable(dn_quo) && $stable(dn_div)));

    // R4: a stage still stepping an operation refuses new work
    a_r4_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt < CW'(CPS)) |-> !up_ready);

endmodule

// File: rtl/nrdiv_fixup.sv
module nrdiv_fixup #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [WIDTH+1:0] rem,
    input  logic [WIDTH-1:0] quo,
    input  logic [WIDTH-1:0] div,
    input  logic             zero,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic [WIDTH+1:0] fixed;

    // One add-back for a negative final partial remainder.
    assign fixed     = rem[WIDTH+1] ? (rem + {2'b00, div}) : rem;
    assign remainder = fixed[WIDTH-1:0];
    assign quotient  = zero ? '0 : quo;

    // R1: corrected remainder is below the divisor
    a_r1_rem_below_div: assert property (@(posedge clk) disable iff (rst)
        (valid && !zero) |-> (fixed < {2'b00, div}));

    // R1: corrected remainder fits the operand width
    a_r1_rem_fits: assert property (@(posedge clk) disable iff (rst)
        valid |-> (fixed[WIDTH+1:WIDTH] == 2'b00));

endmodule

// File: rtl/nrdiv_pipe.sv
module nrdiv_pipe
    import nrdiv_pkg::*;
#(
    parameter int WIDTH            = 48,
    parameter int ITERS_PER_CYCLE  = 1,
    parameter int CYCLES_PER_STAGE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_dividend,
    input  logic [WIDTH-1:0] in_divisor,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_quotient,
    output logic [WIDTH-1:0] out_remainder
);
    localparam int NUM_STAGES = ceil_div(WIDTH, ITERS_PER_CYCLE * CYCLES_PER_STAGE);
    localparam int FW         = $clog2(NUM_STAGES + 2);

    logic             lk_valid [NUM_STAGES+1];
    logic             lk_ready [NUM_STAGES+1];
    logic [WIDTH+1:0] lk_rem   [NUM_STAGES+1];
    logic [WIDTH-1:0] lk_quo   [NUM_STAGES+1];
    logic [WIDTH-1:0] lk_div   [NUM_STAGES+1];
    logic             lk_zero  [NUM_STAGES+1];

    assign lk_valid[0] = in_valid;
    assign in_ready    = lk_ready[0];
    assign lk_rem[0]   = '0;
    assign lk_quo[0]   = in_dividend;
    assign lk_div[0]   = in_divisor;
    assign lk_zero[0]  = (in_divisor == '0);

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        nrdiv_stage #(
            .WIDTH (WIDTH),
            .IPC   (ITERS_PER_CYCLE),
            .CPS   (CYCLES_PER_STAGE),
            .STAGE (s)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .up_valid (lk_valid[s]),
            .up_ready (lk_ready[s]),
            .up_rem   (lk_rem[s]),
            .up_quo   (lk_quo[s]),
            .up_div   (lk_div[s]),
            .up_zero  (lk_zero[s]),
            .dn_valid (lk_valid[s+1]),
            .dn_ready (lk_ready[s+1]),
            .dn_rem   (lk_rem[s+1]),
            .dn_quo   (lk_quo[s+1]),
            .dn_div   (lk_div[s+1]),
            .dn_zero  (lk_zero[s+1])
        );
    end

    assign out_valid              = lk_valid[NUM_STAGES];
    assign lk_ready[NUM_STAGES]   = out_ready;

    nrdiv_fixup #(.WIDTH(WIDTH)) u_fixup (
        .clk       (clk),
        .rst       (rst),
        .valid     (out_valid),
        .rem       (lk_rem[NUM_STAGES]),
        .quo       (lk_quo[NUM_STAGES]),
        .div       (lk_div[NUM_STAGES]),
        .zero      (lk_zero[NUM_STAGES]),
        .quotient  (out_quotient),
        .remainder (out_remainder)
    );

    // Occupancy tracker for the in-flight bound check.
    logic [FW-1:0] inflight;
    always_ff @(posedge clk) begin
        if (rst)
            inflight <= '0;
        else begin
            case ({in_valid && in_ready, out_valid && out_ready})
                2'b10:   inflight <= inflight + FW'(1);
                2'b01:   inflight <= inflight - FW'(1);
                default: inflight <= inflight;
            endcase
        end
    end

    // R4: never more operations in flight than stages
    a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= FW'(NUM_STAGES));

    // R5: a result never appears with nothing outstanding
    a_r5_no_phantom: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

endmodule

// File: tb/nrdiv_pipe_tb.sv
module nrdiv_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 48;
    localparam int CPS  = 16;
    localparam int NS   = 3;
    localparam int LAT  = NS * CPS - 1;
    localparam int WB   = 13;
    localparam int CPSB = 3;
    localparam int NSB  = 3;
    localparam int LATB = NSB * CPSB - 1;
    localparam int NVEC = 12;

    localparam logic [95:0] VEC [NVEC] = '{
        {48'd100,             48'd7},
        {48'd0,               48'd5},
        {48'd5,               48'd0},
        {48'hFFFF_FFFF_FFFF,  48'd1},
        {48'hFFFF_FFFF_FFFF,  48'hFFFF_FFFF_FFFF},
        {48'd3,               48'd10},
        {48'h8000_0000_0000,  48'd3},
        {48'd123456789,       48'd12345},
        {48'hFFFF_FFFF_FFFF,  48'd0},
        {48'd1,               48'd1},
        {48'h1234_5678_9ABC,  48'h0000_0001_0000},
        {48'hABCD_EF01_2345,  48'h8000_0000_0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          in_valid, in_ready, out_valid, out_ready;
    logic [W-1:0]  in_dividend, in_divisor, out_quotient, out_remainder;
    logic          b_in_valid, b_in_ready, b_out_valid, b_out_ready;
    logic [WB-1:0] b_dividend, b_divisor, b_quotient, b_remainder;

    nrdiv_pipe #(.WIDTH(W), .ITERS_PER_CYCLE(1), .CYCLES_PER_STAGE(CPS)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dividend(in_dividend), .in_divisor(in_divisor),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_quotient(out_quotient), .out_remainder(out_remainder)
    );

    nrdiv_pipe #(.WIDTH(WB), .ITERS_PER_CYCLE(2), .CYCLES_PER_STAGE(CPSB)) u_dut_odd (
        .clk(clk), .rst(rst),
        .in_valid(b_in_valid), .in_ready(b_in_ready),
        .in_dividend(b_dividend), .in_divisor(b_divisor),
        .out_valid(b_out_valid), .out_ready(b_out_ready),
        .out_quotient(b_quotient), .out_remainder(b_remainder)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [96:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        if (b == '0) return {1'b1, {W{1'b0}}, a};
        return {1'b0, a / b, a % b};
    endfunction

    logic [96:0] exp_q [$];
    logic [96:0] e_item;
    int          xfer_t [$];
    int          ready_mode = 0;
    logic        held = 1'b0;
    logic [95:0] held_data;

    // Result collector: drives out_ready, checks order, values and stall hold.
    always @(negedge clk) begin
        if (rst) begin
            out_ready = 1'b0;
            held      = 1'b0;
        end else begin
            case (ready_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (cyc % 3) != 1;
                default: out_ready = 1'b0;
            endcase
            if (held) begin
                check(out_valid == 1'b1, "R6 valid held under stall", 64'(out_valid), 64'd1);
                check({out_quotient, out_remainder} == held_data, "R6 result stable under stall",
                      64'(out_quotient), 64'(held_data[95:48]));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 result with none outstanding", 64'(out_quotient), 64'd0);
                end else begin
                    e_item = exp_q.pop_front();
                    check(out_quotient == e_item[95:48],
                          e_item[96] ? "R2 zero-divisor quotient" : "R1 R5 quotient",
                          64'(out_quotient), 64'(e_item[95:48]));
                    check(out_remainder == e_item[47:0],
                          e_item[96] ? "R2 zero-divisor remainder" : "R1 R5 remainder",
                          64'(out_remainder), 64'(e_item[47:0]));
                end
                xfer_t.push_back(cyc);
            end
            held      = out_valid && !out_ready;
            held_data = {out_quotient, out_remainder};
        end
    end

    // Called just after a falling edge; returns just after the falling edge
    // that follows the accepting rising edge.
    task automatic push(input logic [W-1:0] a, input logic [W-1:0] b);
        in_valid = 1'b1; in_dividend = a; in_divisor = b;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        exp_q.push_back(model(a, b));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic try_push(input logic [W-1:0] a, input logic [W-1:0] b,
                            input int max_wait, output bit ok);
        in_valid = 1'b1; in_dividend = a; in_divisor = b;
        #1;
        ok = 1'b0;
        for (int k = 0; k < max_wait; k++) begin
            if (in_ready) begin ok = 1'b1; break; end
            @(negedge clk); #1;
        end
        if (ok) begin
            exp_q.push_back(model(a, b));
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic push_b(input logic [WB-1:0] a, input logic [WB-1:0] b);
        b_in_valid = 1'b1; b_dividend = a; b_divisor = b;
        #1;
        while (!b_in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        b_in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int          n;
        int          acc;
        bit          ok;
        int unsigned seed;
        logic [WB-1:0] ba, bb;
        in_valid = 1'b0; in_dividend = '0; in_divisor = '0;
        b_in_valid = 1'b0; b_dividend = '0; b_divisor = '0; b_out_ready = 1'b1;

        // R9: reset state, during and after reset
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R9 in_ready in reset", 64'(in_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R9 in_ready after reset", 64'(in_ready), 64'd1);
        check(b_out_valid == 1'b0, "R9 odd out_valid after reset", 64'(b_out_valid), 64'd0);
        check(b_in_ready == 1'b1, "R9 odd in_ready after reset", 64'(b_in_ready), 64'd1);

        // R7 latency and R4 first-stage blocking
        ready_mode = 0;
        push(48'd1000, 48'd7);
        #1;
        check(in_ready == 1'b0, "R4 first stage busy after accept", 64'(in_ready), 64'd0);
        n = 0;
        while (!out_valid && n < 500) begin @(negedge clk); n++; end
        check(n == LAT, "R7 latency", 64'(n), 64'(LAT));
        drain();

        // R1 R2 R5 R6: table stream with an irregular output stall pattern
        ready_mode = 1;
        for (int i = 0; i < NVEC; i++) push(VEC[i][95:48], VEC[i][47:0]);
        drain();
        ready_mode = 0;

        // R8: back-to-back stream, output always ready
        xfer_t.delete();
        for (int i = 0; i < 6; i++) push(48'(1000 + 37 * i), 48'(3 + i));
        drain();
        for (int k = 1; k < 6; k++)
            check(xfer_t[k] - xfer_t[k-1] == CPS, "R8 result spacing",
                  64'(xfer_t[k] - xfer_t[k-1]), 64'(CPS));

        // R4: output blocked, only one operation per stage accepted
        ready_mode = 2;
        acc = 0;
        for (int i = 0; i < NS + 1; i++) begin
            try_push(48'(500 + i), 48'(9 + i), 4 * NS * CPS, ok);
            if (ok) acc++;
        end
        check(acc == NS, "R4 accepted while blocked", 64'(acc), 64'(NS));
        repeat (5) @(negedge clk);
        ready_mode = 0;
        drain();

        // R3: odd width, two bits per clock, three clocks per stage
        seed = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            ba = seed[28:16];
            seed = seed * 32'd1103515245 + 32'd12345;
            if (k % 7 == 0)      bb = '0;
            else if (k % 5 == 0) bb = WB'(seed[19:16]);
            else                 bb = seed[28:16];
            if (k == 1) begin ba = '1; bb = 13'd1; end
            if (k == 2) begin ba = '1; bb = '1; end
            push_b(ba, bb);
            n = 0;
            while (!b_out_valid && n < 100) begin @(negedge clk); n++; end
            check(n == LATB, "R3 odd-width latency", 64'(n), 64'(LATB));
            check(b_quotient == ((bb == '0) ? '0 : ba / bb), "R3 odd-width quotient",
                  64'(b_quotient), 64'((bb == '0) ? '0 : ba / bb));
            check(b_remainder == ((bb == '0) ? ba : ba % bb), "R3 odd-width remainder",
                  64'(b_remainder), 64'((bb == '0) ? ba : ba % bb));
            @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule